// File: doc/BRIEF.md
# Power-Fail Interrupt Sampling Filter

This block raises an active-low non-maskable interrupt that warns a processor of an approaching supply failure early enough to shut down in order. An external comparator delivers a synchronous flag that is high while the monitored supply is below its trip point. The block reads that flag once per slow sampling tick. It raises the interrupt only after a run of consecutive low readings, so short supply noise cannot trip it. Once raised, the interrupt stays low for a fixed minimum pulse length.

Two further inputs shape the behaviour. A supply-good flag keeps the filter quiet while the block's own supply is still coming up. A mode select lets a strobe falling-edge pulse force an immediate interrupt while the supply is low. Software uses this to confirm that the supply sits in its warning band. The sampling period, the pulse length and the run length are parameters counted in system clocks and ticks.

Top module: `pwrfail_nmi`

## Requirements
- R1: While reset is asserted and after it is released, `nmi_n` is high (idle) until a trigger occurs; the filter starts armed.
- R2: The sampling tick is a free-running divider that fires on every TICK_DIV-th clock edge after reset release, whatever the sense flag does. The filter only reads `sense_low` on tick edges, so a filter-triggered fall of `nmi_n` happens only on a tick edge.
- R3: When `sense_low` is 1 on RUN_LEN consecutive tick edges, `supply_ok` is 1 and the filter is armed, `nmi_n` goes low right after the tick edge of the RUN_LEN-th low reading.
- R4: A tick edge that reads `sense_low` = 0 clears the run, so a run shorter than RUN_LEN produces no interrupt.
- R5: Each trigger drives `nmi_n` low for exactly PULSE_LEN clock cycles. A return of `sense_low` to 0 during the pulse does not shorten it.
- R6: After the pulse times out with `sense_low` still 1, the filter is disarmed. It re-arms only on a tick edge that reads `sense_low` = 0.
- R7: While `supply_ok` is 0 the run is held at zero and the filter cannot trigger. Counting starts afresh on the ticks after `supply_ok` returns to 1.
- R8: A `strobe_fall` pulse with `cmos_mode` = 1, `sense_low` = 1 and `supply_ok` = 1 drives `nmi_n` low on the next cycle, even when the filter is disarmed. With `cmos_mode` = 0 or `sense_low` = 0 the strobe has no effect.
- R9: Any trigger (filter or strobe) during an active pulse restarts the PULSE_LEN count from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sense_low | input | 1 | 1 while the monitored supply is below its trip level (synchronous) |
| supply_ok | input | 1 | 1 once the block's own supply has reached its good level |
| strobe_fall | input | 1 | One-cycle pulse marking a falling edge of the strobe line |
| cmos_mode | input | 1 | 1 selects the mode in which a strobe can force an interrupt |
| nmi_n | output | 1 | Active-low non-maskable interrupt |

## Verification
The bench places a two-reading low glitch between in-tolerance ticks. A filter that does not clear its run on a good sample would then fire on the next low tick. It holds the sense flag low long past a timeout. A design that re-arms without an in-tolerance reading would fire a second pulse there. It drops the supply-good flag across several low ticks. A design that keeps counting during power-up would fire as soon as the flag returns, not three ticks later. It also overlaps a strobe, a filter trigger and a second strobe within one pulse. A pulse generator that ignores reloads, or that lets a strobe act in the wrong mode, would produce a pulse of the wrong width or a pulse that should not exist.

// File: rtl/pwrfail_nmi_pkg.sv
package pwrfail_nmi_pkg;

   localparam int unsigned DEF_TICK_DIV  = 1650;   // ~33 us at 50 MHz
   localparam int unsigned DEF_PULSE_LEN = 10000;  // 200 us at 50 MHz
   localparam int unsigned DEF_RUN_LEN   = 3;

   function automatic int unsigned cnt_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/pwrfail_nmi_tick.sv
module pwrfail_nmi_tick
   import pwrfail_nmi_pkg::*;
#(
   parameter int unsigned TICK_DIV = DEF_TICK_DIV
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int unsigned W = cnt_width(TICK_DIV);

   generate
      if (TICK_DIV < 2) begin : g_bad
         $error("TICK_DIV must be at least 2");
      end
   endgenerate

   logic [W-1:0] div_q;

   // free-running: never cleared by the sense input
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         div_q <= '0;
      else if (div_q == W'(TICK_DIV - 1))
         div_q <= '0;
      else
         div_q <= div_q + W'(1);
   end

   assign tick = (div_q == W'(TICK_DIV - 1));

endmodule

// File: rtl/pwrfail_nmi_filter.sv
module pwrfail_nmi_filter
   import pwrfail_nmi_pkg::*;
#(
   parameter int unsigned RUN_LEN = DEF_RUN_LEN
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic sense_low,
   input  logic supply_ok,
   output logic fire
);
   logic armed_q;
   logic run_full;

   generate
      if (RUN_LEN < 1) begin : g_bad
         $error("RUN_LEN must be at least 1");
      end
      if (RUN_LEN == 1) begin : g_single
         assign run_full = 1'b1;
      end else begin : g_run
         localparam int unsigned W = cnt_width(RUN_LEN);
         logic [W-1:0] run_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               run_q <= '0;
            else if (!supply_ok)
               run_q <= '0;
            else if (tick) begin
               if (!sense_low)
                  run_q <= '0;
               else if (run_q != W'(RUN_LEN - 1))
                  run_q <= run_q + W'(1);
            end
         end

         assign run_full = (run_q == W'(RUN_LEN - 1));
      end
   endgenerate

   assign fire = tick && supply_ok && sense_low && armed_q && run_full;

   // disarm on trigger, re-arm on an in-tolerance reading
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         armed_q <= 1'b1;
      else if (fire)
         armed_q <= 1'b0;
      else if (tick && !sense_low)
         armed_q <= 1'b1;
   end

endmodule

// File: rtl/pwrfail_nmi_pulse.sv
module pwrfail_nmi_pulse
   import pwrfail_nmi_pkg::*;
#(
   parameter int unsigned PULSE_LEN = DEF_PULSE_LEN
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic active
);
   localparam int unsigned W = cnt_width(PULSE_LEN);

   generate
      if (PULSE_LEN < 2) begin : g_bad
         $error("PULSE_LEN must be at least 2");
      end
   endgenerate

   logic [W-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         left_q <= '0;
      end else if (load) begin
         active <= 1'b1;
         left_q <= W'(PULSE_LEN - 1);
      end else if (active) begin
         if (left_q == '0)
            active <= 1'b0;
         else
            left_q <= left_q - W'(1);
      end
   end

endmodule

// File: rtl/pwrfail_nmi.sv
module pwrfail_nmi
   import pwrfail_nmi_pkg::*;
#(
   parameter int unsigned TICK_DIV  = DEF_TICK_DIV,
   parameter int unsigned PULSE_LEN = DEF_PULSE_LEN,
   parameter int unsigned RUN_LEN   = DEF_RUN_LEN
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sense_low,
   input  logic supply_ok,
   input  logic strobe_fall,
   input  logic cmos_mode,
   output logic nmi_n
);
   logic tick;
   logic filt_fire;
   logic strobe_fire;
   logic pulse_on;

   pwrfail_nmi_tick #(.TICK_DIV(TICK_DIV)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick)
   );

   pwrfail_nmi_filter #(.RUN_LEN(RUN_LEN)) u_filter (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .sense_low (sense_low),
      .supply_ok (supply_ok),
      .fire      (filt_fire)
   );

   assign strobe_fire = strobe_fall && cmos_mode && sense_low && supply_ok;

   pwrfail_nmi_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (filt_fire || strobe_fire),
      .active (pulse_on)
   );

   assign nmi_n = ~pulse_on;

endmodule

// File: rtl/pwrfail_nmi_chk.sv
module pwrfail_nmi_chk (
   input logic clk,
   input logic rst_n,
   input logic sense_low,
   input logic supply_ok,
   input logic strobe_fall,
   input logic cmos_mode,
   input logic tick,
   input logic nmi_n
);

   always @(posedge clk) begin
      if (!rst_n) begin
         AST_RESET_IDLE: assert (nmi_n) else $error("nmi_n low in reset"); // R1
      end
   end

   AST_FALL_ON_TICK_OR_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(nmi_n) |-> ($past(tick) || $past(strobe_fall && cmos_mode))); // R2

   AST_FALL_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(nmi_n) |-> $past(sense_low)); // R3

   AST_FALL_NEEDS_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(nmi_n) |-> $past(supply_ok)); // R7

   AST_MIN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(nmi_n) |=> !nmi_n); // R5

   AST_STROBE_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_fall && cmos_mode && sense_low && supply_ok) |=> !nmi_n); // R8

endmodule

bind pwrfail_nmi pwrfail_nmi_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .sense_low   (sense_low),
   .supply_ok   (supply_ok),
   .strobe_fall (strobe_fall),
   .cmos_mode   (cmos_mode),
   .tick        (tick),
   .nmi_n       (nmi_n)
);

// File: tb/pwrfail_nmi_test.sv
module pwrfail_nmi_test;
   localparam int TDIV  = 8;
   localparam int PLEN  = 40;
   localparam int RUNL  = 3;

   typedef struct {
      int    fall;
      int    width;
      string req;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sense_low = 1'b0;
   logic supply_ok = 1'b1;
   logic strobe_fall = 1'b0;
   logic cmos_mode = 1'b0;
   logic nmi_n;

   int   cyc = 0;
   int   n_chk = 0;
   int   n_fail = 0;
   bit   done = 1'b0;
   exp_t expq[$];

   pwrfail_nmi #(.TICK_DIV(TDIV), .PULSE_LEN(PLEN), .RUN_LEN(RUNL)) uut (
      .clk(clk), .rst_n(rst_n), .sense_low(sense_low), .supply_ok(supply_ok),
      .strobe_fall(strobe_fall), .cmos_mode(cmos_mode), .nmi_n(nmi_n)
   );

   always #10ns clk = ~clk;

   always @(posedge clk) if (rst_n) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s at edge %0d: actual %0d expected %0d", req, cyc, act, exp);
      end
   endtask

   task automatic step_to(input int k);
      while (cyc < k - 1) @(negedge clk);
   endtask

   task automatic push(input int fall, input int width, input string req);
      exp_t e;
      e.fall = fall; e.width = width; e.req = req;
      expq.push_back(e);
   endtask

   task automatic strobe_at(input int k);
      step_to(k);
      strobe_fall = 1'b1;
      step_to(k + 1);
      strobe_fall = 1'b0;
   endtask

   // monitor: pops one expectation per pulse
   logic prev_n = 1'b1;
   int   run_w = 0;
   exp_t cur;
   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_n && !nmi_n) begin
            run_w = 0;
            if (expq.size() == 0) begin
               check(1'b0, "R4 R6 R8 unexpected pulse", cyc, -1);
               cur.fall = cyc; cur.width = -1; cur.req = "none";
            end else begin
               cur = expq.pop_front();
               check(cyc == cur.fall, {cur.req, " fall edge"}, cyc, cur.fall);
            end
         end
         if (!nmi_n) run_w++;
         if (!prev_n && nmi_n && cur.width >= 0)
            check(run_w == cur.width, {cur.req, " pulse width"}, run_w, cur.width);
         prev_n = nmi_n;
      end
   end

   initial begin
      #(20ns * 20000);
      if (!done) begin
         check(1'b0, "watchdog", 0, 1);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(nmi_n == 1'b1, "R1 idle in reset", nmi_n, 1);
      rst_n = 1'b1;
      step_to(11);
      check(nmi_n == 1'b1, "R1 idle after reset", nmi_n, 1);

      // R4: two low readings (ticks 16, 24), then good tick 32
      step_to(14);  sense_low = 1'b1;
      step_to(30);  sense_low = 1'b0;
      step_to(35);
      check(nmi_n == 1'b1, "R4 short run ignored", nmi_n, 1);

      // R3/R2: low on ticks 40, 48, 56 -> fall at 56
      push(56, PLEN, "R3 R2");
      sense_low = 1'b1;
      step_to(56);
      check(nmi_n == 1'b1, "R3 not before third reading", nmi_n, 1);

      // R6: stays low past timeout, no refire
      step_to(141);
      check(nmi_n == 1'b1, "R6 no refire while low", nmi_n, 1);
      step_to(150); sense_low = 1'b0;           // tick 152 re-arms
      step_to(155); sense_low = 1'b1;           // ticks 160,168,176
      push(176, PLEN, "R6 R5");
      step_to(180); sense_low = 1'b0;           // R5: rise does not shorten

      // R7: supply not good blocks counting
      step_to(230); supply_ok = 1'b0;
      step_to(232); sense_low = 1'b1;           // ticks 232..272 low
      step_to(275);
      check(nmi_n == 1'b1, "R7 blocked while supply low", nmi_n, 1);
      supply_ok = 1'b1;                         // ticks 280,288,296
      push(296, PLEN, "R7");
      step_to(297);
      check(nmi_n == 1'b0, "R7 fires after restart", nmi_n, 0);

      // R8: strobe in the strobe-enabled mode while disarmed
      step_to(340); cmos_mode = 1'b1;
      push(345, PLEN, "R8");
      strobe_at(345);
      step_to(390); cmos_mode = 1'b0;
      strobe_at(400);
      step_to(403);
      check(nmi_n == 1'b1, "R8 strobe ignored in other mode", nmi_n, 1);
      step_to(405); cmos_mode = 1'b1;
      step_to(410); sense_low = 1'b0;
      strobe_at(420);
      step_to(423);
      check(nmi_n == 1'b1, "R8 strobe ignored when sense good", nmi_n, 1);

      // R9: strobe at 450, filter at 456, strobe at 470 -> release 510
      step_to(438); sense_low = 1'b1;
      push(450, 470 + PLEN - 450, "R9");
      strobe_at(450);
      strobe_at(470);
      step_to(520); sense_low = 1'b0;
      step_to(600);
      check(expq.size() == 0, "R3 R8 R9 all pulses seen", expq.size(), 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule